// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block holds the access-register state for a device that several software localities share. Each locality has its own 8-bit access register, reached through one read/write port that carries a locality number. A locality writes single-bit commands to its register to ask for the device, hand it back, seize it from a lower-numbered holder, or acknowledge that it lost the device. A read returns a status byte for the selected locality.

The arbiter keeps a single owner at all times, or none. It queues requests, hands a free device to the highest-numbered requester, and tells each locality whether others are waiting. Downstream logic sees the owner index, a valid flag and a one-cycle strobe each time ownership moves. A write is taken at the rising clock edge where `wrEn` is high. Read data is combinational from `locSel`.

Top module: `tpm_locality_arbiter`

## Requirements
- R1: After reset no locality owns the device, `ownerChange` is low, and every in-range locality reads back `0x80` with bit 0 equal to `envNotEst`.
- R2: Read byte for an in-range locality: bit 7 = 1, bit 5 = that locality is the owner, bit 4 = its seized flag, bit 2 = some other locality has an outstanding request, bit 1 = its own request is outstanding, bit 0 = `envNotEst`, bits 6 and 3 = 0. Locality numbers 5 to 7 read `0x00`, and writes to them change nothing.
- R3: Writing 1 to bit 1 from a non-owner records a request. A request from the owner is ignored. While there is no owner, at each clock edge the highest-numbered outstanding request is granted and cleared.
- R4: Writing 1 to bit 5 from the owner clears ownership at that edge. At the next edge the highest-numbered pending requester, if any, becomes owner.
- R5: Writing 1 to bit 5 from a locality that is not the owner has no effect.
- R6: Writing 1 to bit 3 when there is no owner, or when the owner's number is lower than the writer's, makes the writer owner at that edge and clears the writer's request. A displaced owner gets its seized flag set.
- R7: Writing 1 to bit 3 from a locality whose number is lower than or equal to the owner's has no effect.
- R8: Writing 1 to bit 4 clears the writer's seized flag.
- R9: `ownerChange` is high for exactly the one cycle after each edge at which `ownerValid` or `ownerIdx` changed, and low otherwise.
- R10: Within one written byte, bit 5 takes priority over bit 3, and bit 3 over bit 1. A seize taken at the same edge as an automatic grant wins, and the displaced requester stays pending.
- R11: At most one locality reads bit 5 set, and `ownerIdx` is below 5 whenever `ownerValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the selected locality |
| locSel | input | 3 | Locality number for read and write |
| wrData | input | 8 | Command byte written |
| envNotEst | input | 1 | Trusted-environment-not-established flag, returned in bit 0 |
| rdData | output | 8 | Status byte of the selected locality |
| ownerValid | output | 1 | A locality owns the device |
| ownerIdx | output | 3 | Number of the owning locality |
| ownerChange | output | 1 | One-cycle strobe after ownership moved |

## Verification
Two functions can fall in the same cycle: a seize write, and the automatic grant to the highest pending requester in the cycle after a relinquish. The bench provokes this directly. It writes a relinquish, then writes a seize from a locality higher than the waiting requester in the very next cycle. It expects the seizer to own the device and the requester still to read its request bit. Random traffic with multi-bit command bytes hits the same collision, and bit-priority cases within one byte, many more times. A bench model derived from the requirements judges the owner ports, the strobe and the status byte every cycle.

// File: rtl/tpla_pkg.sv
package tpla_pkg;
  localparam int LOC_NUM = 5;
  localparam int LOC_W   = 3;
  localparam int DATA_W  = 8;
  localparam int SLOT_NUM = 1 << LOC_W;

  // command / status bit positions in the access byte
  localparam int B_VALID  = 7;
  localparam int B_ACTIVE = 5;
  localparam int B_SEIZED = 4;
  localparam int B_SEIZE  = 3;
  localparam int B_PEND   = 2;
  localparam int B_REQ    = 1;
  localparam int B_ENV    = 0;

  typedef struct packed {
    logic               takeOwn;
    logic [LOC_W-1:0]   newOwner;
    logic               dropOwn;
    logic               markVictim;
    logic [LOC_NUM-1:0] reqSet;
    logic [LOC_NUM-1:0] reqClr;
    logic [LOC_NUM-1:0] seizeClr;
  } ctrlStb_t;
endpackage

// File: rtl/tpla_ctrl.sv
module tpla_ctrl
  import tpla_pkg::*;
(
  input  logic               wrEn,
  input  logic [LOC_W-1:0]   locSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               ownV,
  input  logic [LOC_W-1:0]   ownIdx,
  input  logic [LOC_NUM-1:0] reqVec,
  output ctrlStb_t           stb
);
  localparam logic [LOC_W-1:0]   LOC_LAST = LOC_W'(LOC_NUM - 1);
  localparam logic [LOC_NUM-1:0] ONE_HOT0 = LOC_NUM'(1);

  logic             wrOk, isOwner, doRel, doSeize, doReq, autoGrant;
  logic [LOC_W-1:0] hiReq;

  always_comb begin
    hiReq = '0;
    for (int i = 0; i < LOC_NUM; i++) begin
      if (reqVec[i]) hiReq = LOC_W'(i);
    end
  end

  always_comb begin
    wrOk      = wrEn && (locSel <= LOC_LAST);
    isOwner   = ownV && (ownIdx == locSel);
    doRel     = wrOk && wrData[B_ACTIVE] && isOwner;
    doSeize   = wrOk && !doRel && wrData[B_SEIZE] && (!ownV || (ownIdx < locSel));
    doReq     = wrOk && !doRel && !doSeize && wrData[B_REQ] && !isOwner;
    autoGrant = !ownV && (|reqVec) && !doSeize;

    stb            = '0;
    stb.dropOwn    = doRel;
    stb.takeOwn    = doSeize || autoGrant;
    stb.newOwner   = doSeize ? locSel : hiReq;
    stb.markVictim = doSeize && ownV;
    stb.reqSet     = doReq ? (ONE_HOT0 << locSel) : '0;
    stb.reqClr     = (doSeize || autoGrant) ? (ONE_HOT0 << stb.newOwner) : '0;
    stb.seizeClr   = (wrOk && wrData[B_SEIZED]) ? (ONE_HOT0 << locSel) : '0;
  end
endmodule

// File: rtl/tpla_data.sv
module tpla_data
  import tpla_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [LOC_W-1:0]   locSel,
  input  logic               envNotEst,
  output logic               ownV,
  output logic [LOC_W-1:0]   ownIdx,
  output logic [LOC_NUM-1:0] reqVec,
  output logic               chg,
  output logic [DATA_W-1:0]  rdData
);
  localparam logic [LOC_NUM-1:0] ONE_HOT0 = LOC_NUM'(1);

  logic [LOC_NUM-1:0] seizedVec;
  logic               nxtV;
  logic [LOC_W-1:0]   nxtIdx;
  logic [DATA_W-1:0]  slotView [SLOT_NUM];

  always_comb begin
    nxtV   = ownV;
    nxtIdx = ownIdx;
    if (stb.dropOwn) nxtV = 1'b0;
    if (stb.takeOwn) begin
      nxtV   = 1'b1;
      nxtIdx = stb.newOwner;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownV      <= 1'b0;
      ownIdx    <= '0;
      reqVec    <= '0;
      seizedVec <= '0;
      chg       <= 1'b0;
    end else begin
      ownV      <= nxtV;
      ownIdx    <= nxtIdx;
      chg       <= (nxtV != ownV) || (nxtV && (nxtIdx != ownIdx));
      reqVec    <= (reqVec | stb.reqSet) & ~stb.reqClr;
      seizedVec <= (seizedVec | (stb.markVictim ? (ONE_HOT0 << ownIdx) : '0))
                   & ~stb.seizeClr;
    end
  end

  for (genvar g = 0; g < SLOT_NUM; g++) begin : gSlot
    if (g < LOC_NUM) begin : gLive
      always_comb begin
        slotView[g]           = '0;
        slotView[g][B_VALID]  = 1'b1;
        slotView[g][B_ACTIVE] = ownV && (ownIdx == LOC_W'(g));
        slotView[g][B_SEIZED] = seizedVec[g];
        slotView[g][B_PEND]   = |(reqVec & ~(ONE_HOT0 << g));
        slotView[g][B_REQ]    = reqVec[g];
        slotView[g][B_ENV]    = envNotEst;
      end
    end else begin : gDead
      assign slotView[g] = '0;
    end
  end

  assign rdData = slotView[locSel];
endmodule

// File: rtl/tpm_locality_arbiter.sv
module tpm_locality_arbiter
  import tpla_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [LOC_W-1:0]  locSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              envNotEst,
  output logic [DATA_W-1:0] rdData,
  output logic              ownerValid,
  output logic [LOC_W-1:0]  ownerIdx,
  output logic              ownerChange
);
  ctrlStb_t           stb;
  logic [LOC_NUM-1:0] reqVec;

  tpla_ctrl uCtrl (
    .wrEn   (wrEn),
    .locSel (locSel),
    .wrData (wrData),
    .ownV   (ownerValid),
    .ownIdx (ownerIdx),
    .reqVec (reqVec),
    .stb    (stb)
  );

  tpla_data uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .locSel    (locSel),
    .envNotEst (envNotEst),
    .ownV      (ownerValid),
    .ownIdx    (ownerIdx),
    .reqVec    (reqVec),
    .chg       (ownerChange),
    .rdData    (rdData)
  );
endmodule

// File: rtl/tpla_checker.sv
module tpla_checker
  import tpla_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [LOC_W-1:0]  locSel,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              ownerValid,
  input logic [LOC_W-1:0]  ownerIdx,
  input logic              ownerChange
);
  localparam logic [LOC_W-1:0] LOC_LAST = LOC_W'(LOC_NUM - 1);

  p_valid_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (locSel <= LOC_LAST) |-> rdData[B_VALID]);

  p_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[B_ACTIVE] && ownerValid && locSel == ownerIdx) |=> !ownerValid);

  p_seize_up_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && locSel <= LOC_LAST && wrData[B_SEIZE] && !wrData[B_ACTIVE]
     && ownerValid && ownerIdx < locSel)
    |=> (ownerValid && ownerIdx == $past(locSel)));

  p_seize_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ownerValid && locSel < ownerIdx)
    |=> (ownerValid && ownerIdx == $past(ownerIdx)));

  p_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ownerValid != $past(ownerValid) || (ownerValid && ownerIdx != $past(ownerIdx)))
    |-> ownerChange);

  p_idx_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    ownerValid |-> (ownerIdx <= LOC_LAST));

  p_active_r11: assert property (@(posedge clk) disable iff (!rstN)
    (locSel <= LOC_LAST) |-> (rdData[B_ACTIVE] == (ownerValid && ownerIdx == locSel)));
endmodule

bind tpm_locality_arbiter tpla_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .locSel      (locSel),
  .wrData      (wrData),
  .rdData      (rdData),
  .ownerValid  (ownerValid),
  .ownerIdx    (ownerIdx),
  .ownerChange (ownerChange)
);

// File: tb/sim_tpm_locality_arbiter.sv
`timescale 1ns/1ps
module sim_tpm_locality_arbiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] locSel = '0;
  logic [7:0] wrData = '0;
  logic       envNotEst = 1'b1;
  logic [7:0] rdData;
  logic       ownerValid;
  logic [2:0] ownerIdx;
  logic       ownerChange;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit       mV = 0;
  int       mI = 0;
  bit [4:0] mReq = '0;
  bit [4:0] mSz = '0;
  bit       mChg = 0;

  always #10 clk = ~clk;

  tpm_locality_arbiter u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .locSel(locSel), .wrData(wrData),
    .envNotEst(envNotEst), .rdData(rdData), .ownerValid(ownerValid),
    .ownerIdx(ownerIdx), .ownerChange(ownerChange)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] expByte(int loc);
    bit [7:0] b;
    if (loc > 4) return 8'h00;
    b = 8'h80;
    b[5] = mV && (mI == loc);
    b[4] = mSz[loc];
    b[2] = |(mReq & ~(5'b1 << loc));
    b[1] = mReq[loc];
    b[0] = envNotEst;
    return b;
  endfunction

  function automatic int hiReq(bit [4:0] r);
    int h = 0;
    for (int i = 0; i < 5; i++) if (r[i]) h = i;
    return h;
  endfunction

  // one clock: drive, advance model, check owner ports
  task automatic step(string tag, bit we, int loc, bit [7:0] d);
    bit nV; int nI; bit [4:0] nR; bit [4:0] nS;
    bit ok, rel, sz, rq;
    wrEn = we; locSel = loc[2:0]; wrData = d;
    nV = mV; nI = mI; nR = mReq; nS = mSz;
    ok  = we && loc <= 4;
    rel = ok && d[5] && mV && mI == loc;
    sz  = ok && !rel && d[3] && (!mV || mI < loc);
    rq  = ok && !rel && !sz && d[1] && !(mV && mI == loc);
    if (rel) nV = 0;
    if (rq) nR[loc] = 1;
    if (sz) begin
      if (mV) nS[mI] = 1;
      nV = 1; nI = loc; nR[loc] = 0;
    end else if (!mV && mReq != 0) begin
      nV = 1; nI = hiReq(mReq); nR[nI] = 0;
    end
    if (ok && d[4]) nS[loc] = 0;
    @(posedge clk);
    mChg = (nV != mV) || (nV && nI != mI);
    mV = nV; mI = nI; mReq = nR; mSz = nS;
    @(negedge clk);
    wrEn = 0;
    check({tag, " ownerValid"}, ownerValid, mV);
    if (mV) check({tag, " ownerIdx"}, ownerIdx, mI);
    check({tag, " R9 ownerChange"}, ownerChange, mChg);
  endtask

  task automatic readChk(string tag, int loc);
    wrEn = 0; locSel = loc[2:0];
    #1;
    check({tag, " rdData"}, rdData, expByte(loc));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 ownerValid", ownerValid, 0);
    check("R1 ownerChange", ownerChange, 0);
    for (int l = 0; l < 5; l++) readChk("R1", l);
    rstN = 1;
    @(negedge clk);
    readChk("R2 out of range", 6);
    step("R2 write out of range", 1, 6, 8'h0A);
    check("R2 no owner", ownerValid, 0);

    // R3 request then grant
    step("R3 req", 1, 1, 8'h02);
    step("R3 grant", 0, 0, 8'h00);
    check("R3 owner1", ownerIdx, 1);
    step("R3 req3", 1, 3, 8'h02);
    step("R3 req2", 1, 2, 8'h02);
    readChk("R2 pending seen", 1);
    readChk("R2 own req", 3);
    step("R3 owner req ignored", 1, 1, 8'h02);
    readChk("R3 owner no req", 1);
    // R5 / R7
    step("R5 nonowner release", 1, 0, 8'h20);
    check("R5 owner kept", ownerIdx, 1);
    step("R7 low seize", 1, 0, 8'h08);
    check("R7 owner kept", ownerIdx, 1);
    step("R7 self seize", 1, 1, 8'h08);
    readChk("R7 no seized flag", 1);
    // R4 relinquish -> highest pending
    step("R4 release", 1, 1, 8'h20);
    check("R4 none", ownerValid, 0);
    step("R4 handoff", 0, 0, 8'h00);
    check("R4 highest", ownerIdx, 3);
    // R6 seize and R8 clear
    step("R6 seize", 1, 4, 8'h08);
    check("R6 owner4", ownerIdx, 4);
    readChk("R6 victim seized", 3);
    step("R8 clear", 1, 3, 8'h10);
    readChk("R8 cleared", 3);
    // R10 seize same cycle as auto-grant
    step("R10 release", 1, 4, 8'h20);
    step("R10 seize vs grant", 1, 3, 8'h08);
    check("R10 seizer wins", ownerIdx, 3);
    readChk("R10 loc2 still pending", 2);
    // R10 bit priority in one byte
    step("R10 byte priority", 1, 3, 8'h2A);
    check("R10 release wins", ownerValid, 0);
    step("R10 grant2", 0, 0, 8'h00);
    readChk("R10 loc3 no req", 3);

    // R11 random traffic
    for (int n = 0; n < 3000; n++) begin
      int loc; bit [7:0] d; int sel;
      sel = $urandom_range(0, 9);
      loc = (sel == 0) ? $urandom_range(5, 7) : $urandom_range(0, 4);
      d = 8'($urandom()) & 8'h3A;
      if ($urandom_range(0, 7) == 0) envNotEst = ~envNotEst;
      step("R11 random", $urandom_range(0, 3) != 0, loc, d);
      readChk("R11 random", $urandom_range(0, 7));
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule